// File: doc/BRIEF.md
# Dual-Rail Enable Sequencer

This block is the digital controller that switches two supply rails (a 3.3V rail and a 5V rail) on and off. It combines an active-low shutdown input, a two-bit mode select, a run input and an auxiliary input, and produces an enable for each rail, a discharge-pulldown request and a coarse power-state code. The shutdown input overrides every other input. While it is released, the mode select chooses one of three behaviours. In independent control, each of the two inputs switches one rail. In 5V-first sequencing and 3.3V-first sequencing, the run input is the master control for both rails. In the sequenced modes, the second rail follows the first after a fixed number of clock cycles set by a parameter, and the auxiliary input has no effect.

All outputs are registered, so an input change shows at the outputs one clock edge after it is sampled. After reset is released, a short power-up window holds both rails off and keeps the discharge pulldown active. Normal decoding starts once that window has ended.

Top module: `dual_rail_sequencer`

## Requirements
- R1: While shdn_n is sampled low, the next edge drives en_3v3=0, en_5v=0, discharge=1 and pwr_state=2'b00, whatever the other inputs are.
- R2: With mode_sel=2'b00 (independent), en_3v3 follows run_in and en_5v follows aux_in with one edge of latency.
- R3: mode_sel=2'b11 behaves exactly like 2'b00.
- R4: With mode_sel=2'b01 (5V first), en_5v rises on the first edge at which run_in is sampled high, and en_3v3 rises exactly DELAY_CYCLES edges later.
- R5: With mode_sel=2'b10 (3.3V first), en_3v3 rises on the first edge at which run_in is sampled high, and en_5v rises exactly DELAY_CYCLES edges later.
- R6: In a sequenced mode, sampling run_in low turns both rails off on the next edge. The delay restarts from zero, so a later rise waits the full DELAY_CYCLES again.
- R7: pwr_state is 2'b00 in shutdown, 2'b01 in standby (both rails off) and 2'b10 in run (at least one rail on). discharge is 1 exactly when pwr_state is not run.
- R8: For the first PWRUP_CYCLES edges after reset is released, both rails stay off and discharge=1. pwr_state reads 2'b01, or 2'b00 if shdn_n is low. The sequencing delay does not advance during this window.
- R9: While rst is high, the outputs are en_3v3=0, en_5v=0, discharge=1 and pwr_state=2'b00.
- R10: In the sequenced modes aux_in has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shdn_n | input | 1 | Active-low hard shutdown |
| mode_sel | input | 2 | 00/11 independent, 01 5V first, 10 3.3V first |
| run_in | input | 1 | 3.3V enable (independent) or master on/off (sequenced) |
| aux_in | input | 1 | 5V enable in independent mode, ignored otherwise |
| en_3v3 | output | 1 | 3.3V rail enable |
| en_5v | output | 1 | 5V rail enable |
| discharge | output | 1 | Output discharge pulldown request |
| pwr_state | output | 2 | 00 shutdown, 01 standby, 10 run |

## Verification
The bench aims at the edge where the second rail turns on. A counter that is off by one, or that compares against the wrong value, moves that rise one cycle early or late, and the cycle-exact reference model catches it. Dropping the master and raising it again mid-delay tests the restart rule: a counter that is not cleared brings the second rail up too soon. Toggling aux_in in the sequenced modes and using the spare 2'b11 code would expose a decoder that lets the auxiliary input leak through or that treats the spare code as a sequenced mode. Asserting shutdown and reset in the middle of a run checks that they override everything, and that the power-up window reopens after a reset.

// File: rtl/dual_rail_seq_pkg.sv
package dual_rail_seq_pkg;

    typedef enum logic [1:0] {
        MODE_INDEP     = 2'b00,
        MODE_5V_FIRST  = 2'b01,
        MODE_3V3_FIRST = 2'b10,
        MODE_SPARE     = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        PS_SHUTDOWN = 2'b00,
        PS_STANDBY  = 2'b01,
        PS_RUN      = 2'b10
    } pstate_e;

    typedef struct packed {
        logic    en_3v3;
        logic    en_5v;
        logic    discharge;
        pstate_e state;
    } rail_ctrl_t;

    localparam rail_ctrl_t CTRL_SHUTDOWN = '{en_3v3: 1'b0, en_5v: 1'b0, discharge: 1'b1, state: PS_SHUTDOWN};
    localparam rail_ctrl_t CTRL_STANDBY  = '{en_3v3: 1'b0, en_5v: 1'b0, discharge: 1'b1, state: PS_STANDBY};

    function automatic logic is_sequenced(mode_e m);
        return (m == MODE_5V_FIRST) || (m == MODE_3V3_FIRST);
    endfunction

    function automatic rail_ctrl_t make_ctrl(logic e33, logic e5);
        rail_ctrl_t c;
        c.en_3v3    = e33;
        c.en_5v     = e5;
        c.discharge = !(e33 || e5);
        c.state     = (e33 || e5) ? PS_RUN : PS_STANDBY;
        return c;
    endfunction

endpackage

// File: rtl/powerup_window.sv
module powerup_window #(
    parameter int unsigned PWRUP_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    output logic done
);
    localparam int unsigned W = $clog2(PWRUP_CYCLES + 1);
    localparam logic [W-1:0] LIMIT = W'(PWRUP_CYCLES);

    logic [W-1:0] cnt_q;

    assign done = (cnt_q == LIMIT);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (!done)
            cnt_q <= cnt_q + 1'b1;
    end

    AST_WINDOW_STAYS_CLOSED: assert property (@(posedge clk) disable iff (rst)
        done |=> done); // R8

endmodule

// File: rtl/rail_delay.sv
module rail_delay #(
    parameter int unsigned DELAY_CYCLES = 800
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic expired
);
    localparam int unsigned W = $clog2(DELAY_CYCLES + 1);
    localparam logic [W-1:0] LIMIT = W'(DELAY_CYCLES);

    logic [W-1:0] cnt_q;

    assign expired = (cnt_q == LIMIT);

    always_ff @(posedge clk) begin
        if (rst || !arm)
            cnt_q <= '0;
        else if (!expired)
            cnt_q <= cnt_q + 1'b1;
    end

    AST_DELAY_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT); // R4

    AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !arm |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/rail_decoder.sv
module rail_decoder
    import dual_rail_seq_pkg::*;
(
    input  logic       shdn_n,
    input  mode_e      mode,
    input  logic       run_in,
    input  logic       aux_in,
    input  logic       window_done,
    input  logic       delay_expired,
    output logic       arm,
    output rail_ctrl_t nxt
);
    always_comb begin
        arm = shdn_n && window_done && run_in && is_sequenced(mode);
        if (!shdn_n) begin
            nxt = CTRL_SHUTDOWN;
        end else if (!window_done) begin
            nxt = CTRL_STANDBY;
        end else begin
            case (mode)
                MODE_5V_FIRST:  nxt = make_ctrl(run_in && delay_expired, run_in);
                MODE_3V3_FIRST: nxt = make_ctrl(run_in, run_in && delay_expired);
                default:        nxt = make_ctrl(run_in, aux_in);
            endcase
        end
    end
endmodule

// File: rtl/dual_rail_sequencer.sv
module dual_rail_sequencer
    import dual_rail_seq_pkg::*;
#(
    parameter int unsigned DELAY_CYCLES = 800,
    parameter int unsigned PWRUP_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       shdn_n,
    input  logic [1:0] mode_sel,
    input  logic       run_in,
    input  logic       aux_in,
    output logic       en_3v3,
    output logic       en_5v,
    output logic       discharge,
    output logic [1:0] pwr_state
);
    mode_e      mode;
    logic       window_done;
    logic       delay_expired;
    logic       arm;
    rail_ctrl_t ctrl_nxt;
    rail_ctrl_t ctrl_q;

    assign mode = mode_e'(mode_sel);

    powerup_window #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_window (
        .clk  (clk),
        .rst  (rst),
        .done (window_done)
    );

    rail_delay #(.DELAY_CYCLES(DELAY_CYCLES)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .arm     (arm),
        .expired (delay_expired)
    );

    rail_decoder u_decode (
        .shdn_n        (shdn_n),
        .mode          (mode),
        .run_in        (run_in),
        .aux_in        (aux_in),
        .window_done   (window_done),
        .delay_expired (delay_expired),
        .arm           (arm),
        .nxt           (ctrl_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= CTRL_SHUTDOWN;
        else
            ctrl_q <= ctrl_nxt;
    end

    assign en_3v3    = ctrl_q.en_3v3;
    assign en_5v     = ctrl_q.en_5v;
    assign discharge = ctrl_q.discharge;
    assign pwr_state = ctrl_q.state;

    AST_SHDN_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
        !shdn_n |=> (!en_3v3 && !en_5v && discharge && pwr_state == 2'b00)); // R1

    AST_MASTER_DROP: assert property (@(posedge clk) disable iff (rst)
        (is_sequenced(mode) && !run_in) |=> (!en_3v3 && !en_5v)); // R6

    AST_RUN_NO_DISCHARGE: assert property (@(posedge clk) disable iff (rst)
        (en_3v3 || en_5v) |-> (!discharge && pwr_state == 2'b10)); // R7

    AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !window_done |=> (!en_3v3 && !en_5v && discharge)); // R8

endmodule

// File: tb/dual_rail_sequencer_tb_top.sv
module dual_rail_sequencer_tb_top;
    localparam int D = 24;
    localparam int P = 6;

    logic       clk = 1'b0;
    logic       rst, shdn_n, run_in, aux_in;
    logic [1:0] mode_sel;
    logic       en_3v3, en_5v, discharge;
    logic [1:0] pwr_state;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dual_rail_sequencer #(.DELAY_CYCLES(D), .PWRUP_CYCLES(P)) dut_i (
        .clk(clk), .rst(rst), .shdn_n(shdn_n), .mode_sel(mode_sel),
        .run_in(run_in), .aux_in(aux_in), .en_3v3(en_3v3), .en_5v(en_5v),
        .discharge(discharge), .pwr_state(pwr_state)
    );

    // Reference model built from the requirements
    int         m_win, m_dly;
    logic [4:0] exp_v;   // {en_3v3, en_5v, discharge, state[1:0]}
    string      exp_tag;

    function automatic logic [4:0] pack(logic e33, logic e5);
        return {e33, e5, !(e33 || e5), ((e33 || e5) ? 2'b10 : 2'b01)};
    endfunction

    function automatic string tag_for(logic sd, int win, logic [1:0] m);
        if (!sd) return "R1";
        if (win != P) return "R8";
        case (m)
            2'b00: return "R2";
            2'b11: return "R3";
            2'b01: return "R4";
            default: return "R5";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_win   <= 0;
            m_dly   <= 0;
            exp_v   <= 5'b00100;
            exp_tag <= "R9";
        end else begin
            logic seq, done;
            seq  = (mode_sel == 2'b01) || (mode_sel == 2'b10);
            done = (m_win == P);
            m_dly   <= (shdn_n && seq && run_in && done) ? ((m_dly == D) ? D : m_dly + 1) : 0;
            m_win   <= done ? m_win : m_win + 1;
            exp_tag <= tag_for(shdn_n, m_win, mode_sel);
            if (!shdn_n)              exp_v <= 5'b00100;
            else if (!done)           exp_v <= 5'b00101;
            else if (mode_sel == 2'b01) exp_v <= pack(run_in && (m_dly == D), run_in);
            else if (mode_sel == 2'b10) exp_v <= pack(run_in, run_in && (m_dly == D));
            else                      exp_v <= pack(run_in, aux_in);
        end
    end

    task automatic check_outputs(input string tag);
        logic [4:0] act;
        string      t;
        act = {en_3v3, en_5v, discharge, pwr_state};
        t   = (tag == "") ? exp_tag : tag;
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: outputs {en3v3,en5v,dis,state} actual=%b expected=%b at %0t", t, act, exp_v, $time);
        end
        checks++;
        if (discharge !== (pwr_state != 2'b10)) begin // R7 invariant
            errors++;
            $display("FAIL R7: discharge actual=%b expected=%b (state=%b)", discharge, pwr_state != 2'b10, pwr_state);
        end
    endtask

    task automatic tick(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            check_outputs(tag);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EC0_1234));
        rst = 1'b1; shdn_n = 1'b1; mode_sel = 2'b01; run_in = 1'b0; aux_in = 1'b0;
        tick(3, "R9");                        // R9 reset values
        rst = 1'b0;
        tick(P + 2, "");                      // R8 power-up window, then standby
        run_in = 1'b1;
        tick(D + 3, "");                      // R4 5V first, 3.3V after D
        run_in = 1'b0;
        tick(1, "R6");                        // R6 immediate drop
        run_in = 1'b1;
        tick(D / 2, "R6");
        run_in = 1'b0;
        tick(1, "R6");
        run_in = 1'b1;
        tick(D + 2, "R6");                    // R6 full delay again after restart
        run_in = 1'b0; mode_sel = 2'b10;
        tick(2, "");
        run_in = 1'b1;
        for (int i = 0; i < D + 4; i++) begin // R5 with R10 aux toggling
            aux_in = ~aux_in;
            tick(1, "R10");
        end
        mode_sel = 2'b00; aux_in = 1'b1; shdn_n = 1'b0;
        tick(3, "R1");                        // R1 shutdown overrides
        shdn_n = 1'b1; mode_sel = 2'b11;
        for (int c = 0; c < 4; c++) begin     // R3 spare code acts as independent
            {run_in, aux_in} = c[1:0];
            tick(2, "R3");
        end
        mode_sel = 2'b00;
        for (int c = 0; c < 4; c++) begin     // R2 independent combinations
            {run_in, aux_in} = c[1:0];
            tick(2, "R2");
        end
        for (int i = 0; i < 6000; i++) begin  // constrained random
            if ($urandom_range(39) == 0) mode_sel = 2'($urandom_range(3));
            if ($urandom_range(79) == 0) shdn_n = ~shdn_n;
            if ($urandom_range(29) == 0) run_in = ~run_in;
            if ($urandom_range(3) == 0)  aux_in = ~aux_in;
            if (i == 3000) begin
                rst = 1'b1;
                tick(2, "R9");
                rst = 1'b0;
            end
            tick(1, "");
        end
        finish_run();
    end
endmodule